// File: doc/BRIEF.md
# Clock Fanout Buffer Control Register File

This block is the slave-side register file for a two-output clock fanout buffer that is managed over SMBus. A byte-level SMBus engine handles the wire signalling. It passes the block start and stop indications, each received byte, and a pulse for each read byte it has shifted out. The block decides which bytes to acknowledge. It stores the control, output-enable, function-select and byte-count registers, and it supplies the fixed revision, vendor and device identifiers.

Two outputs steer the PLL: the bandwidth select and the PLL enable. A software-enable bit in the control register chooses their source. When the bit is clear, the bandwidth follows the bandwidth pin and the PLL stays enabled. When the bit is set, both follow the register bits. Two active-low clock-request inputs become per-output enables.

A write transaction has three parts: the write address, a command byte that gives the starting register index, and then data bytes. The data bytes go to ascending indexes. A read transaction always begins at index 0. It returns as many bytes as the byte-count register holds, and after that it returns 0xFF.

Top module: `clkbuf_smb_regs`

## Requirements
- R1: After reset, a block read returns index 0 = 0x03, index 1 = 0x00, index 2 = 0x00, index 3 = {REV_ID[3:0], 4'h1}, index 4 = 0x06, index 5 = 0x06.
- R2: The address byte that follows a start is acknowledged only if it is 0xDC (write) or 0xDD (read). After any other address, no byte is acknowledged and no register changes until the next start.
- R3: In a write, the byte after the address sets the register index. Each later data byte is stored at the current index, which then increments. All of these bytes are acknowledged.
- R4: Writes to index 3 (revision/vendor ID) and index 4 (device ID) are acknowledged but leave those registers unchanged. Indexes above 5 also accept and discard data.
- R5: A read returns the registers in ascending order from index 0, one byte for each read pulse, until the byte count is reached. After that, every pulse returns 0xFF and the position stops advancing. Positions from 6 up to the count also return 0xFF.
- R6: Writing 0 to the byte count (index 5) stores 1.
- R7: While control bit 7 (software enable) is 0, the bandwidth output equals the bandwidth pin (0 = low, 1 = high) and the PLL enable output is 1.
- R8: While control bit 7 is 1, the bandwidth output equals control bit 1 and the PLL enable output equals control bit 0 (1 = PLL mode, 0 = bypass).
- R9: Each output enable is 1 exactly when its active-low clock-request input is 0.
- R10: Received bytes that arrive outside a transaction (before a start, or after a stop) are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated start seen (one-cycle pulse) |
| stop_i | input | 1 | Stop seen (one-cycle pulse) |
| rx_valid_i | input | 1 | Received byte is valid this cycle |
| rx_byte_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge for the byte on rx_byte_i |
| tx_take_i | input | 1 | Current read byte has been sent; advance |
| tx_byte_o | output | 8 | Next byte to send in a read |
| pin_bw_i | input | 1 | Bandwidth select pin (0 low, 1 high) |
| clkreq_n_i | input | NUM_OUT | Active-low clock requests |
| oe_o | output | NUM_OUT | Per-output enables |
| pll_bw_o | output | 1 | Resolved PLL bandwidth select |
| pll_en_o | output | 1 | Resolved PLL enable (0 = bypass) |

## Verification
The bench builds the block with REV_ID = 4'hA, so the revision nibble cannot be confused with the zero reset value of the reserved registers. NUM_OUT stays at its default of 2, which lets all four clock-request patterns be applied. Byte counts of 0, 3, 6 and 8 exercise the clamp to 1, a short read, the exact register span, and positions past the register span.

// File: rtl/clkbuf_smb_regs.sv
module clkbuf_smb_regs #(
  parameter int unsigned NUM_OUT   = 2,
  parameter logic [7:0]  WR_ADDR   = 8'hDC,
  parameter logic [3:0]  REV_ID    = 4'h0,
  parameter logic [3:0]  VENDOR_ID = 4'h1,
  parameter logic [7:0]  DEVICE_ID = 8'h06,
  parameter logic [7:0]  CNT_INIT  = 8'h06
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  output logic               ack_o,
  input  logic               tx_take_i,
  output logic [7:0]         tx_byte_o,
  input  logic               pin_bw_i,
  input  logic [NUM_OUT-1:0] clkreq_n_i,
  output logic [NUM_OUT-1:0] oe_o,
  output logic               pll_bw_o,
  output logic               pll_en_o
);
  localparam logic [7:0] RD_ADDR  = WR_ADDR | 8'h01;
  localparam logic [7:0] LAST_IDX = 8'd5;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_CMD, PH_WDATA, PH_READ} phase_t;

  phase_t     phase;
  logic [7:0] ctrl_q, oe_reg_q, fsel_q, cnt_q;
  logic [7:0] wr_idx, rd_idx;

  wire sw_en = ctrl_q[7];
  wire addr_hit = (rx_byte_i == WR_ADDR) || (rx_byte_i == RD_ADDR);

  always_comb begin
    ack_o = 1'b0;
    if (rx_valid_i && !start_i) begin
      case (phase)
        PH_ADDR:  ack_o = addr_hit;
        PH_CMD:   ack_o = 1'b1;
        PH_WDATA: ack_o = 1'b1;
        default:  ack_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    tx_byte_o = 8'hFF;
    if (rd_idx < cnt_q) begin
      case (rd_idx)
        8'd0:    tx_byte_o = ctrl_q;
        8'd1:    tx_byte_o = oe_reg_q;
        8'd2:    tx_byte_o = fsel_q;
        8'd3:    tx_byte_o = {REV_ID, VENDOR_ID};
        8'd4:    tx_byte_o = DEVICE_ID;
        8'd5:    tx_byte_o = cnt_q;
        default: tx_byte_o = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      ctrl_q   <= 8'h03;
      oe_reg_q <= 8'h00;
      fsel_q   <= 8'h00;
      cnt_q    <= CNT_INIT;
      wr_idx   <= 8'd0;
      rd_idx   <= 8'd0;
    end else if (start_i) begin
      phase <= PH_ADDR;
    end else if (stop_i) begin
      phase <= PH_IDLE;
    end else begin
      if (rx_valid_i) begin
        case (phase)
          PH_ADDR: begin
            if (rx_byte_i == WR_ADDR) phase <= PH_CMD;
            else if (rx_byte_i == RD_ADDR) begin
              phase  <= PH_READ;
              rd_idx <= 8'd0;
            end else phase <= PH_IDLE;
          end
          PH_CMD: begin
            wr_idx <= rx_byte_i;
            phase  <= PH_WDATA;
          end
          PH_WDATA: begin
            case (wr_idx)
              8'd0:    ctrl_q   <= rx_byte_i;
              8'd1:    oe_reg_q <= rx_byte_i;
              8'd2:    fsel_q   <= rx_byte_i;
              8'd5:    cnt_q    <= (rx_byte_i == 8'd0) ? 8'd1 : rx_byte_i;
              default: ;
            endcase
            if (wr_idx != 8'hFF && wr_idx <= LAST_IDX) wr_idx <= wr_idx + 8'd1;
            else if (wr_idx != 8'hFF) wr_idx <= wr_idx + 8'd1;
          end
          default: ;
        endcase
      end
      if (phase == PH_READ && tx_take_i && rd_idx < cnt_q)
        rd_idx <= rd_idx + 8'd1;
    end
  end

  assign oe_o     = ~clkreq_n_i;
  assign pll_bw_o = sw_en ? ctrl_q[1] : pin_bw_i;
  assign pll_en_o = sw_en ? ctrl_q[0] : 1'b1;
endmodule

module clkbuf_smb_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       rx_valid_i,
  input logic       ack_o,
  input logic [7:0] tx_byte_o,
  input logic       pin_bw_i,
  input logic       pll_bw_o,
  input logic       pll_en_o,
  input logic [7:0] ctrl_q,
  input logic [7:0] cnt_q,
  input logic [7:0] rd_idx,
  input logic [2:0] phase
);
  a_r6_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != 8'd0);
  a_r5_hold_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && rd_idx >= cnt_q) |-> tx_byte_o == 8'hFF);
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) |-> rd_idx <= cnt_q);
  a_r2_ack_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> rx_valid_i);
  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !start_i && rx_valid_i) |-> !ack_o);
  a_r7_pin_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[7] |-> (pll_en_o && pll_bw_o == pin_bw_i));
  a_r8_reg_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] |-> (pll_en_o == ctrl_q[0] && pll_bw_o == ctrl_q[1]));
endmodule

bind clkbuf_smb_regs clkbuf_smb_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_valid_i(rx_valid_i),
  .ack_o(ack_o), .tx_byte_o(tx_byte_o), .pin_bw_i(pin_bw_i),
  .pll_bw_o(pll_bw_o), .pll_en_o(pll_en_o), .ctrl_q(ctrl_q),
  .cnt_q(cnt_q), .rd_idx(rd_idx), .phase(phase)
);

// File: tb/clkbuf_smb_regs_tb.sv
module clkbuf_smb_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] REV = 4'hA;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, stop_i = 0, rx_valid_i = 0, tx_take_i = 0, pin_bw_i = 0;
  logic [7:0] rx_byte_i = 0;
  logic [1:0] clkreq_n_i = 2'b11;
  logic ack_o, pll_bw_o, pll_en_o;
  logic [7:0] tx_byte_o;
  logic [1:0] oe_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] model [0:5];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clkbuf_smb_regs #(.REV_ID(REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .ack_o(ack_o),
    .tx_take_i(tx_take_i), .tx_byte_o(tx_byte_o), .pin_bw_i(pin_bw_i),
    .clkreq_n_i(clkreq_n_i), .oe_o(oe_o), .pll_bw_o(pll_bw_o), .pll_en_o(pll_en_o));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (tx_take_i) begin
      if (exp_q.size() == 0) check("R5 unexpected read byte", tx_byte_o, 8'hxx);
      else check(tag_q.pop_front(), tx_byte_o, exp_q.pop_front());
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic do_start(); start_i = 1; cyc(); start_i = 0; endtask
  task automatic do_stop();  stop_i = 1;  cyc(); stop_i = 0;  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
    rx_valid_i = 1; rx_byte_i = b;
    @(negedge clk); check(tag, {7'd0, ack_o}, {7'd0, exp_ack});
    cyc(); rx_valid_i = 0;
  endtask

  task automatic wr(input int idx, input logic [7:0] d, input string tag);
    do_start();
    send(8'hDC, 1, tag);
    send(idx[7:0], 1, tag);
    send(d, 1, tag);
    do_stop();
    if (idx <= 2) model[idx] = d;
    else if (idx == 5) model[5] = (d == 0) ? 8'd1 : d;
  endtask

  task automatic rd(input int n, input string tag);
    do_start();
    send(8'hDD, 1, tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back((i < model[5] && i < 6) ? model[i] : 8'hFF);
      tag_q.push_back(tag);
      tx_take_i = 1; cyc(); tx_take_i = 0; cyc();
    end
    do_stop();
  endtask

  task automatic pll_chk(input string tag, input logic bw, input logic en);
    @(negedge clk);
    check(tag, {7'd0, pll_bw_o}, {7'd0, bw});
    check(tag, {7'd0, pll_en_o}, {7'd0, en});
    cyc();
  endtask

  initial begin
    model[0] = 8'h03; model[1] = 8'h00; model[2] = 8'h00;
    model[3] = {REV, 4'h1}; model[4] = 8'h06; model[5] = 8'h06;
    cyc(); cyc(); rst_n = 1; cyc();

    pin_bw_i = 1; pll_chk("R7 reset pin mode high", 1, 1);
    pin_bw_i = 0; pll_chk("R7 reset pin mode low", 0, 1);
    rd(8, "R1 R5 reset read");

    wr(0, 8'h80, "R8 write ctrl");
    pin_bw_i = 1; pll_chk("R8 reg low bw bypass", 0, 0);
    wr(0, 8'h82, "R8 write ctrl");
    pll_chk("R8 reg high bw bypass", 1, 0);

    do_start();
    send(8'hDC, 1, "R3 addr"); send(8'h01, 1, "R3 cmd");
    send(8'hA5, 1, "R3 data1"); send(8'h5A, 1, "R3 data2");
    send(8'h77, 1, "R4 data3 acked"); send(8'h66, 1, "R4 data4 acked");
    do_stop();
    model[1] = 8'hA5; model[2] = 8'h5A;
    wr(3, 8'h99, "R4 ro write");
    wr(4, 8'h55, "R4 ro write");
    wr(7, 8'h12, "R4 out of range write");
    rd(6, "R3 R4 readback");

    wr(5, 8'h00, "R6 count zero");
    rd(3, "R6 count clamp");
    wr(5, 8'h03, "R5 count three");
    rd(5, "R5 count three");
    wr(5, 8'h08, "R5 count eight");
    rd(10, "R5 count eight");

    do_start();
    send(8'hA0, 0, "R2 foreign addr nack");
    send(8'h00, 0, "R2 follow nack");
    send(8'h00, 0, "R2 follow nack");
    do_stop();
    send(8'h00, 0, "R10 after stop");
    send(8'hDC, 0, "R10 no start");
    rd(6, "R2 R10 unchanged");

    wr(0, 8'h03, "R7 back to pins");
    pin_bw_i = 1; pll_chk("R7 pins high", 1, 1);
    pin_bw_i = 0; pll_chk("R7 pins low", 0, 1);

    for (int p = 0; p < 4; p++) begin
      clkreq_n_i = p[1:0];
      @(negedge clk); check("R9 oe", {6'd0, oe_o}, {6'd0, ~p[1:0]});
      cyc();
    end

    cyc();
    check("R5 queue drained", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule